// File: doc/BRIEF.md
# Line Flyback Phase Correction Loop

This block is the digital second phase loop of a horizontal deflection chain. Each line it watches a synchronous flyback pulse against an externally supplied line counter. It takes the centre of the first complete pulse as the mean of the rising-edge and falling-edge counts. It then measures the distance from the horizontal output start to that centre and compares it with a programmable target distance.

A fraction of the resulting error is added to a phase-offset register. With the default factor of one half, the remaining error halves every line. The offset register sets the count at which the horizontal output start pulse fires. The offset is held inside a control range tied to the line length, roughly 37 % of one line. A line without a complete flyback pulse leaves the offset untouched and raises a missing-flyback flag.

The line counter, line length and target position come from the surrounding timing logic as 12-bit values.

Top module: `line_flyback_phase_loop`

## Requirements
- R1: While `rst_n` is low, `phase_off` is 0 and `fb_missing` is 0, and both keep those values until the first end of line after reset.
- R2: The last count of a line is the cycle in which `line_cnt == line_len - 1`. `phase_off` and `fb_missing` change only on the clock edge at the end of such a cycle and hold their values through every other cycle.
- R3: The rising count is the `line_cnt` value of the first cycle in the line in which `flyback` is 1 after being 0 in the previous cycle. The falling count is the `line_cnt` value of the first later cycle in which `flyback` is 0 after being 1. An edge that falls on the last count of a line is not counted. The centre is floor((rise + fall) / 2).
- R4: At the end of a line with a complete pulse, error = centre − `phase_off` − `ref_pos` as a signed value. The new offset is `phase_off` + floor(error / 2), where the division rounds toward minus infinity.
- R5: The new offset from R4 is clamped to the range 0 to floor(`line_len` × 379 / 1024), which is about 37 % of the line.
- R6: If a line ends without a complete pulse (no rise, or a rise without a later fall before the last count), `fb_missing` becomes 1 and `phase_off` keeps its value.
- R7: `fb_missing` returns to 0 at the end of the next line that holds a complete pulse.
- R8: `hout_start` is 1 exactly in the cycles where `line_cnt == phase_off`.
- R9: When a line holds more than one pulse, only the first complete pulse is measured. Later edges in that line are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cnt | input | 12 | Current count within the line, 0 to line_len−1 |
| line_len | input | 12 | Line length in counts |
| ref_pos | input | 12 | Target distance from output start to flyback centre |
| flyback | input | 1 | Flyback pulse, synchronous to clk |
| phase_off | output | 12 | Corrected output phase offset |
| hout_start | output | 1 | One-cycle output start at the offset count |
| fb_missing | output | 1 | Last line had no complete flyback pulse |

## Verification
Edge capture and line closing can fall in the same cycle: a flyback rising or falling edge can land on the last count of a line, where the pulse capture state is cleared and the update is taken. The bench provokes this with directed lines whose pulse starts on the last count, or stays high across it and ends in the next line. It judges the result by expecting `fb_missing` to rise and the offset to stay unchanged, then expects a normal pulse in the following line to restore tracking. Random lines with pulses near the line end and changing line lengths exercise the same boundary alongside the halving and clamping arithmetic.

// File: rtl/line_phase_pkg.sv
package line_phase_pkg;

   // Rounding variant applied to the scaled error.
   typedef enum logic [0:0] {
      RND_FLOOR   = 1'b0,
      RND_HALF_UP = 1'b1
   } round_mode_e;

   // Largest counter width the block accepts.
   localparam int unsigned MAX_CW = 16;

   // Largest synchroniser depth the block accepts.
   localparam int unsigned MAX_SYNC = 3;

endpackage

// File: rtl/fbk_edge_capture.sv
module fbk_edge_capture #(
   parameter int unsigned CW          = 12,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flyback,
   input  logic [CW-1:0] line_cnt,
   input  logic          eol,
   output logic [CW-1:0] rise_cnt,
   output logic [CW-1:0] fall_cnt,
   output logic          pulse_ok
);

   logic fb_s;
   logic fb_q;
   logic seen_rise;
   logic seen_fall;
   logic rise_ev;
   logic fall_ev;

   // Optional resynchronisation of the flyback pulse.
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign fb_s = flyback;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= SYNC_STAGES'({sync_q, flyback});
            end
         end
         assign fb_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise_ev = fb_s & ~fb_q & ~seen_rise;
   assign fall_ev = ~fb_s & fb_q & seen_rise & ~seen_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fb_q      <= 1'b0;
         seen_rise <= 1'b0;
         seen_fall <= 1'b0;
         rise_cnt  <= '0;
         fall_cnt  <= '0;
      end else begin
         fb_q <= fb_s;
         if (eol) begin
            seen_rise <= 1'b0;
            seen_fall <= 1'b0;
         end else if (rise_ev) begin
            rise_cnt  <= line_cnt;
            seen_rise <= 1'b1;
         end else if (fall_ev) begin
            fall_cnt  <= line_cnt;
            seen_fall <= 1'b1;
         end
      end
   end

   assign pulse_ok = seen_rise & seen_fall;

endmodule

// File: rtl/phase_err_calc.sv
module phase_err_calc
   import line_phase_pkg::*;
#(
   parameter int unsigned CW     = 12,
   parameter int unsigned KSHIFT = 1,
   parameter round_mode_e ROUND  = RND_FLOOR,
   localparam int unsigned EW    = CW + 3
) (
   input  logic [CW-1:0]        rise_cnt,
   input  logic [CW-1:0]        fall_cnt,
   input  logic [CW-1:0]        phase,
   input  logic [CW-1:0]        ref_pos,
   output logic signed [EW-1:0] corr
);

   logic [CW:0]          pair_sum;
   logic [CW-1:0]        centre;
   logic signed [EW-1:0] err;

   assign pair_sum = {1'b0, rise_cnt} + {1'b0, fall_cnt};
   assign centre   = CW'(pair_sum >> 1);
   assign err      = $signed({3'b000, centre})
                   - $signed({3'b000, phase})
                   - $signed({3'b000, ref_pos});

   generate
      if (ROUND == RND_FLOOR) begin : g_floor
         assign corr = err >>> KSHIFT;
      end else begin : g_half_up
         localparam logic signed [EW-1:0] HALF = EW'(2 ** (KSHIFT - 1));
         logic signed [EW-1:0] biased;
         assign biased = err + HALF;
         assign corr   = biased >>> KSHIFT;
      end
   endgenerate

endmodule

// File: rtl/phase_offset_reg.sv
module phase_offset_reg #(
   parameter int unsigned CW      = 12,
   parameter int unsigned LIM_NUM = 379,
   parameter int unsigned LIM_SH  = 10,
   localparam int unsigned EW     = CW + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eol,
   input  logic                 pulse_ok,
   input  logic signed [EW-1:0] corr,
   input  logic [CW-1:0]        line_len,
   output logic [CW-1:0]        phase_q,
   output logic                 missing_q
);

   logic signed [EW-1:0] sum;
   logic [CW-1:0]        lim;
   logic [CW-1:0]        nxt;

   assign sum = $signed({3'b000, phase_q}) + corr;
   assign lim = CW'((32'(line_len) * 32'(LIM_NUM)) >> LIM_SH);

   always_comb begin
      if (sum < 0) begin
         nxt = '0;
      end else if (sum > $signed({3'b000, lim})) begin
         nxt = lim;
      end else begin
         nxt = sum[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= '0;
         missing_q <= 1'b0;
      end else if (eol) begin
         if (pulse_ok) begin
            phase_q   <= nxt;
            missing_q <= 1'b0;
         end else begin
            missing_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/line_flyback_phase_loop.sv
module line_flyback_phase_loop
   import line_phase_pkg::*;
#(
   parameter int unsigned CW          = 12,
   parameter int unsigned KSHIFT      = 1,
   parameter round_mode_e ROUND       = RND_FLOOR,
   parameter int unsigned LIM_NUM     = 379,
   parameter int unsigned LIM_SH      = 10,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] line_cnt,
   input  logic [CW-1:0] line_len,
   input  logic [CW-1:0] ref_pos,
   input  logic          flyback,
   output logic [CW-1:0] phase_off,
   output logic          hout_start,
   output logic          fb_missing
);

   localparam int unsigned EW = CW + 3;

   // Elaboration-time parameter checks.
   generate
      if (CW < 4 || CW > MAX_CW) begin : g_bad_cw
         $error("line_flyback_phase_loop: CW out of range");
      end
      if (KSHIFT < 1 || KSHIFT >= CW) begin : g_bad_k
         $error("line_flyback_phase_loop: KSHIFT out of range");
      end
      if (LIM_SH > 15 || LIM_NUM > (2 ** LIM_SH)) begin : g_bad_lim
         $error("line_flyback_phase_loop: limit ratio must not exceed one");
      end
      if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("line_flyback_phase_loop: SYNC_STAGES too large");
      end
   endgenerate

   logic                 eol;
   logic [CW-1:0]        rise_cnt;
   logic [CW-1:0]        fall_cnt;
   logic                 pulse_ok;
   logic signed [EW-1:0] corr;

   assign eol = (line_cnt == (line_len - CW'(1)));

   fbk_edge_capture #(
      .CW          (CW),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .flyback  (flyback),
      .line_cnt (line_cnt),
      .eol      (eol),
      .rise_cnt (rise_cnt),
      .fall_cnt (fall_cnt),
      .pulse_ok (pulse_ok)
   );

   phase_err_calc #(
      .CW     (CW),
      .KSHIFT (KSHIFT),
      .ROUND  (ROUND)
   ) u_err (
      .rise_cnt (rise_cnt),
      .fall_cnt (fall_cnt),
      .phase    (phase_off),
      .ref_pos  (ref_pos),
      .corr     (corr)
   );

   phase_offset_reg #(
      .CW      (CW),
      .LIM_NUM (LIM_NUM),
      .LIM_SH  (LIM_SH)
   ) u_off (
      .clk       (clk),
      .rst_n     (rst_n),
      .eol       (eol),
      .pulse_ok  (pulse_ok),
      .corr      (corr),
      .line_len  (line_len),
      .phase_q   (phase_off),
      .missing_q (fb_missing)
   );

   assign hout_start = (line_cnt == phase_off);

endmodule

// File: rtl/line_phase_checker.sv
module line_phase_checker #(
   parameter int unsigned CW      = 12,
   parameter int unsigned LIM_NUM = 379,
   parameter int unsigned LIM_SH  = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eol,
   input logic [CW-1:0] line_len,
   input logic [CW-1:0] phase_off,
   input logic          fb_missing
);

   logic [CW-1:0] lim_now;
   assign lim_now = CW'((32'(line_len) * 32'(LIM_NUM)) >> LIM_SH);

   // R2: offset holds outside the end-of-line cycle
   p_hold_midline_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(phase_off));

   // R2: flag holds outside the end-of-line cycle
   p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(fb_missing));

   // R6: a missing pulse leaves the offset where it was
   p_miss_no_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (fb_missing -> (phase_off == $past(phase_off))));

   // R5: a corrected offset never leaves the control range
   p_clamp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (!fb_missing -> (phase_off <= $past(lim_now))));

endmodule

bind line_flyback_phase_loop line_phase_checker #(
   .CW      (CW),
   .LIM_NUM (LIM_NUM),
   .LIM_SH  (LIM_SH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eol        (eol),
   .line_len   (line_len),
   .phase_off  (phase_off),
   .fb_missing (fb_missing)
);

// File: tb/line_flyback_phase_loop_tb.sv
module line_flyback_phase_loop_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] line_cnt;
   logic [11:0] line_len;
   logic [11:0] ref_pos;
   logic        flyback;
   logic [11:0] phase_off;
   logic        hout_start;
   logic        fb_missing;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   // model state
   int    m_phase = 0;
   int    m_miss  = 0;
   int    m_prev  = 0;
   int    pend    = 0;
   string pend_tag;

   always #2.5 clk = ~clk;

   line_flyback_phase_loop u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_cnt   (line_cnt),
      .line_len   (line_len),
      .ref_pos    (ref_pos),
      .flyback    (flyback),
      .phase_off  (phase_off),
      .hout_start (hout_start),
      .fb_missing (fb_missing)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int fb_at(input int c, input int r1, input int f1,
                                input int r2, input int f2);
      return ((c >= r1 && c < f1) || (c >= r2 && c < f2)) ? 1 : 0;
   endfunction

   function automatic int floor_half(input int e);
      return (e >= 0) ? e / 2 : -((-e + 1) / 2);
   endfunction

   function automatic int limit_of(input int len);
      return (len * 379) / 1024;
   endfunction

   // Model of one line's end-of-line update (R3 R4 R5 R6 R7 R9)
   task automatic model_line(input int L, input int rf, input int r1, input int f1,
                             input int r2, input int f2);
      int p = m_prev;
      int sr = 0, sf = 0, rise = 0, fall = 0;
      for (int c = 0; c < L - 1; c++) begin
         int v = fb_at(c, r1, f1, r2, f2);
         if (!sr && v == 1 && p == 0) begin
            rise = c; sr = 1;
         end else if (sr && !sf && v == 0 && p == 1) begin
            fall = c; sf = 1;
         end
         p = v;
      end
      m_prev = fb_at(L - 1, r1, f1, r2, f2);
      if (sr && sf) begin
         int centre = (rise + fall) / 2;
         int err    = centre - m_phase - rf;
         int n      = m_phase + floor_half(err);
         int lim    = limit_of(L);
         if (n < 0) n = 0;
         if (n > lim) n = lim;
         m_phase = n;
         m_miss  = 0;
      end else begin
         m_miss = 1;
      end
   endtask

   task automatic check_pending();
      if (pend) begin
         check({pend_tag, " phase_off"}, int'(phase_off), m_phase);
         check({pend_tag, " fb_missing"}, int'(fb_missing), m_miss);
         pend = 0;
      end
   endtask

   task automatic run_line(input int L, input int rf, input int r1, input int f1,
                           input int r2, input int f2, input string tag);
      int line_phase = m_phase;
      int hout_bad   = 0;
      for (int c = 0; c < L; c++) begin
         @(negedge clk);
         if (c == 0) check_pending();
         line_len = 12'(L);
         ref_pos  = 12'(rf);
         line_cnt = 12'(c);
         flyback  = fb_at(c, r1, f1, r2, f2) != 0;
         #1;
         if (hout_start !== (c == line_phase)) hout_bad++;
         if (int'(phase_off) != line_phase) hout_bad++;
      end
      model_line(L, rf, r1, f1, r2, f2);
      pend     = 1;
      pend_tag = tag;
      check({tag, " R8 R2 hout_start/offset mid-line mismatches"}, hout_bad, 0);
   endtask

   initial begin
      void'($urandom(32'd5150));
      rst_n    = 1'b0;
      line_cnt = '0;
      line_len = 12'd100;
      ref_pos  = '0;
      flyback  = 1'b0;
      repeat (4) @(negedge clk);
      check("R1 reset phase_off", int'(phase_off), 0);
      check("R1 reset fb_missing", int'(fb_missing), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release phase_off", int'(phase_off), 0);
      check("R1 after release fb_missing", int'(fb_missing), 0);

      // R3 R4: halving convergence toward the target
      for (int i = 0; i < 6; i++) run_line(100, 10, 40, 50, 0, 0, "R4 halving");
      // R3: odd sum, centre rounds down
      run_line(100, 10, 40, 51, 0, 0, "R3 odd centre");
      // R6: no pulse at all
      run_line(100, 10, 0, 0, 0, 0, "R6 no pulse");
      // R7: recovery
      run_line(100, 10, 30, 36, 0, 0, "R7 recover");
      // R6: pulse still high across the last count
      run_line(100, 10, 70, 100, 0, 0, "R6 open pulse");
      // R3: fall at count 0 of the next line is ignored, second edge pair used
      run_line(100, 10, 20, 28, 0, 0, "R3 R7 after open pulse");
      // R3 R6: rise on the last count only
      run_line(100, 10, 99, 100, 0, 0, "R3 R6 edge on last count");
      run_line(100, 10, 44, 48, 0, 0, "R7 recover after last-count edge");
      // R9: two pulses, first one measured
      run_line(100, 5, 20, 30, 60, 80, "R9 two pulses");
      run_line(100, 5, 15, 17, 18, 90, "R9 close pulses");
      // R5: upper clamp
      for (int i = 0; i < 3; i++) run_line(100, 0, 85, 95, 0, 0, "R5 upper clamp");
      // R5: lower clamp
      for (int i = 0; i < 3; i++) run_line(100, 60, 5, 7, 0, 0, "R5 lower clamp");
      // R5: longest line
      run_line(4095, 0, 4000, 4050, 0, 0, "R5 long line");
      run_line(4095, 0, 4000, 4050, 0, 0, "R5 long line");

      // Random lines
      for (int i = 0; i < 300; i++) begin
         int L  = 64 + int'($urandom_range(136));
         int r  = 1 + int'($urandom_range(L - 11));
         int w  = 1 + int'($urandom_range(39));
         int f  = (r + w > L - 2) ? L - 2 : r + w;
         int rf = int'($urandom_range(L / 3));
         int k  = int'($urandom_range(9));
         if (k == 0) run_line(L, rf, 0, 0, 0, 0, "R6 random none");
         else if (k == 1) run_line(L, rf, r, L, 0, 0, "R6 random open");
         else if (k == 2) run_line(L, rf, L - 1, L, 0, 0, "R3 random last-count edge");
         else if (k == 3 && f + 3 < L - 2) run_line(L, rf, r, f, f + 2, L - 2, "R9 random two");
         else run_line(L, rf, r, f, 0, 0, "R4 R5 random");
      end
      @(negedge clk);
      check_pending();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   // Watchdog
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got %0d expected %0d", cycles, 190000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule